// File: doc/BRIEF.md
# Interrupt Flag Register with Zero-Write Clear

This block holds sixteen independent interrupt flags for a peripheral. Single-cycle event pulses from the peripheral set the flags. Software clears them through a simple synchronous register bus. A flag clears only where software writes a 0 to its bit; a 1 in the written word leaves the flag as it is. To drop one flag, software writes the inverse of that flag's mask. No read-modify-write is needed, so flags raised after the last read survive.

The whole update happens on one clock edge. For each bit, a hardware set beats a software clear in the same cycle, so an event that lands during a clearing write is never lost. A companion enable register masks the flags. The interrupt request is raised while any flag is both set and enabled.

Top module: `irqStatusReg`

## Requirements
- R1: A synchronous active-high reset clears the flag register and the enable register to all zeros, and the interrupt request reads 0.
- R2: A one-cycle pulse on an event input sets the matching flag on the next clock edge, and the flag stays set after the pulse ends.
- R3: A bus write to the flag register (address 0) clears every flag whose written data bit is 0.
- R4: A bus write to the flag register never sets a flag: a written 1 leaves that flag unchanged.
- R5: An event on a bit that arrives in the same cycle as a write of 0 to that bit leaves the flag set.
- R6: Writing the inverse of one flag's mask clears only that flag. Every other flag keeps its value, including a flag whose event arrives in that same cycle.
- R7: Reading the flag register returns the current flags and changes none of them.
- R8: The enable register (address 1) is written and read back in full. The interrupt request is 1 exactly when some bit is set in both the flag register and the enable register.
- R9: A write to any address other than 0 or 1 changes no register, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Register address: 0 = flags, 1 = enables |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, from the registered values |
| eventPulse | input | 16 | Per-bit event pulses from the peripheral |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A software clear and a hardware event can hit the flag register on the same clock edge. The bench provokes this by driving a clearing write and an event pulse in one cycle. It does this twice: once with the event on the bit being cleared, and once with the event on a different bit. After the edge, the bench reads the flag register back over the bus and compares it with the value the set-over-clear rule predicts. The check fails if the write lost the event, or if the write touched a flag outside its zero bits.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  // Strobes passed from address decode to the register datapath
  typedef struct packed {
    logic wrFlags;
    logic wrEnables;
    logic selFlags;
    logic selEnables;
  } regStrobes_t;

endpackage

// File: rtl/irqStatusCtrl.sv
module irqStatusCtrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int FLAGS_ADDR  = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobes_t       strobes
);

  logic hitFlags;
  logic hitEnables;

  assign hitFlags   = (busAddr == ADDR_W'(FLAGS_ADDR));
  assign hitEnables = (busAddr == ADDR_W'(ENABLE_ADDR));

  always_comb begin
    strobes            = '0;
    strobes.selFlags   = hitFlags;
    strobes.selEnables = hitEnables;
    strobes.wrFlags    = hitFlags & busWrEn;
    strobes.wrEnables  = hitEnables & busWrEn;
  end

  // A single bus access never reaches both registers
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.wrFlags, strobes.wrEnables})); // R9

  // Without an address hit, no write strobe fires
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!strobes.selFlags && !strobes.selEnables) |-> !(strobes.wrFlags || strobes.wrEnables)); // R9

endmodule

// File: rtl/irqStatusDatapath.sv
module irqStatusDatapath
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] eventPulse,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  logic [DATA_W-1:0] flagsQ;
  logic [DATA_W-1:0] flagsNext;
  logic [DATA_W-1:0] enablesQ;
  logic [DATA_W-1:0] keepMask;

  // A written 0 drops a flag; new events are OR-ed in last, so a set wins
  assign keepMask  = strobes.wrFlags ? busWrData : '1;
  assign flagsNext = (flagsQ & keepMask) | eventPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagsQ   <= '0;
      enablesQ <= '0;
    end else begin
      flagsQ <= flagsNext;
      if (strobes.wrEnables) begin
        enablesQ <= busWrData;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (strobes.selFlags) begin
      busRdData = flagsQ;
    end else if (strobes.selEnables) begin
      busRdData = enablesQ;
    end
  end

  assign irqOut = |(flagsQ & enablesQ);

  // Every pulsed event is present one edge later
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|eventPulse) |=> ((flagsQ & $past(eventPulse)) == $past(eventPulse))); // R5

  // With no flag write, no flag ever falls
  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrFlags |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ))); // R7

  // A flag write cannot raise a flag on its own
  AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    strobes.wrFlags |=> ((flagsQ & ~$past(flagsQ) & ~$past(eventPulse)) == '0)); // R4

  // A written 0 without a same-bit event ends cleared
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strobes.wrFlags |=> ((flagsQ & ~$past(busWrData) & ~$past(eventPulse)) == '0)); // R3

  // The request needs at least one set flag
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (flagsQ != '0)); // R8

endmodule

// File: rtl/irqStatusReg.sv
module irqStatusReg
  import irq_status_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int FLAGS_ADDR  = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] eventPulse,
  output logic              irqOut
);

  regStrobes_t strobes;

  irqStatusCtrl #(
    .ADDR_W      (ADDR_W),
    .FLAGS_ADDR  (FLAGS_ADDR),
    .ENABLE_ADDR (ENABLE_ADDR)
  ) ctrl (
    .clk     (clk),
    .rst     (rst),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  irqStatusDatapath #(
    .DATA_W (DATA_W)
  ) dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .busWrData  (busWrData),
    .eventPulse (eventPulse),
    .busRdData  (busRdData),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/irqStatusReg_test.sv
module irqStatusReg_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic [DATA_W-1:0] eventPulse = '0;
  logic              irqOut;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqStatusReg uut (
    .clk        (clk),
    .rst        (rst),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .eventPulse (eventPulse),
    .irqOut     (irqOut)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // One cycle with optional write and events; returns at the next falling edge
  task automatic cycle(input logic we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] ev);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; eventPulse = ev;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; eventPulse = '0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    logic [DATA_W-1:0] v;
    doReset();
    readReg(4'd0, v); check("R1 flags after reset", v, 16'h0000);
    readReg(4'd1, v); check("R1 enables after reset", v, 16'h0000);
    check("R1 irq after reset", {15'd0, irqOut}, 16'h0000);
  endtask

  task automatic testEventSet();
    logic [DATA_W-1:0] v;
    cycle(1'b0, 4'd0, 16'h0000, 16'h0208);
    readReg(4'd0, v); check("R2 flags set by pulses", v, 16'h0208);
    cycle(1'b0, 4'd0, 16'h0000, 16'h0000);
    readReg(4'd0, v); check("R2 flags held after pulse", v, 16'h0208);
    readReg(4'd0, v); check("R7 second read unchanged", v, 16'h0208);
  endtask

  task automatic testWriteOnes();
    logic [DATA_W-1:0] v;
    cycle(1'b1, 4'd0, 16'hFFFF, 16'h0000);
    readReg(4'd0, v); check("R4 ones written leave flags", v, 16'h0208);
  endtask

  task automatic testClear();
    logic [DATA_W-1:0] v;
    cycle(1'b1, 4'd0, 16'hFFF7, 16'h0000);
    readReg(4'd0, v); check("R3 zero clears bit 3", v, 16'h0200);
  endtask

  task automatic testSameBitRace();
    logic [DATA_W-1:0] v;
    cycle(1'b1, 4'd0, 16'hFDFF, 16'h0200);
    readReg(4'd0, v); check("R5 event beats clear on bit 9", v, 16'h0200);
  endtask

  task automatic testOtherBitRace();
    logic [DATA_W-1:0] v;
    cycle(1'b1, 4'd0, 16'hFDFF, 16'h0020);
    readReg(4'd0, v); check("R6 clear bit 9 keeps event on bit 5", v, 16'h0020);
    cycle(1'b0, 4'd0, 16'h0000, 16'h1000);
    cycle(1'b1, 4'd0, 16'hEFFF, 16'h0000);
    readReg(4'd0, v); check("R6 inverse mask clears only bit 12", v, 16'h0020);
  endtask

  task automatic testEnables();
    logic [DATA_W-1:0] v;
    cycle(1'b1, 4'd1, 16'h0020, 16'h0000);
    readReg(4'd1, v); check("R8 enable readback", v, 16'h0020);
    check("R8 irq with enabled flag", {15'd0, irqOut}, 16'h0001);
    readReg(4'd0, v); check("R8 enable write leaves flags", v, 16'h0020);
    cycle(1'b1, 4'd1, 16'h0001, 16'h0000);
    check("R8 irq with flag masked", {15'd0, irqOut}, 16'h0000);
  endtask

  task automatic testUnmapped();
    logic [DATA_W-1:0] v;
    cycle(1'b1, 4'd7, 16'h0000, 16'h0000);
    readReg(4'd0, v); check("R9 unmapped write leaves flags", v, 16'h0020);
    readReg(4'd1, v); check("R9 unmapped write leaves enables", v, 16'h0001);
    readReg(4'd7, v); check("R9 unmapped read is zero", v, 16'h0000);
  endtask

  initial begin
    testReset();
    testEventSet();
    testWriteOnes();
    testClear();
    testSameBitRace();
    testOtherBitRace();
    testEnables();
    testUnmapped();
    testReset();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) begin
      @(posedge clk);
    end
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule